// File: doc/BRIEF.md
# Storage Controller Configuration Register File

This block is the 32-bit memory-mapped register file that sits in front of a storage controller with host-managed submission and completion queues. Software uses it to mask interrupts, write the controller configuration word, describe the admin queues (their sizes and 64-bit base addresses), and then read back the controller status. The queue engines, the bus endpoint and the message-interrupt logic are outside this block. They see only the pulses and values it drives.

Setting the enable bit in the configuration word starts a one-cycle validation. The block checks the admin queue bases, the memory page size, the I/O entry sizes and the admin queue sizes, and confirms that no queue already exists. The result goes into the status register as ready or as a fatal flag. Clearing enable, or requesting shutdown, produces a one-cycle clear pulse toward the rest of the controller. A shutdown request is acknowledged at once in the status word. The configured page size is driven out as a shift amount.

Access rules are strict. Misaligned or narrow accesses are dropped and set a sticky error flag. Writes to read-only, reserved or unmapped offsets change nothing. Reads past the end of the register span return zero.

Top module: `sctl_cfg_regs`

## Requirements
- R1: After reset every register reads zero, `ctrl_clear`, `sreset_unsup` and `acc_err` are low, and `page_shift` is 12.
- R2: A write at offset 0x0C ORs the data into the 32-bit interrupt mask, and a write at 0x10 clears the written bits from it. Reads of either offset return the current mask.
- R3: The configuration word at 0x14 has these fields: enable in bit 0, page-size code (MPS) in bits 10:7, shutdown request in bits 15:14 (active when non-zero), I/O submission entry-size code in bits 19:16 and I/O completion entry-size code in bits 23:20. A write stores the data when enable and shutdown are both clear in the old and the new value. A write that keeps enable set and leaves the shutdown state unchanged does not change the stored word.
- R4: A write that sets enable while it was clear stores the word and runs the start checks. If they all pass, the status register at 0x1C becomes 0x1: ready (bit 0) set, fatal (bit 1) clear, shutdown state (bits 3:2) zero.
- R5: On the same enable edge the status becomes 0x2 (fatal set, ready clear) if any of these holds: `queues_live` is high; either admin base is zero; either admin base is not a multiple of the new page size; MPS is outside [MPS_MIN, MPS_MAX]; the submission entry code is outside [SQES_MIN, SQES_MAX]; the completion entry code is outside [CQES_MIN, CQES_MAX]; or either admin size field (bits 11:0 or 27:16 of 0x24) is zero.
- R6: A write that clears enable while it was set stores the word, clears status bit 0 and pulses `ctrl_clear` high for exactly one cycle.
- R7: A write that makes the shutdown field non-zero from zero pulses `ctrl_clear`, stores the word and sets status bits 3:2 to 2 (shutdown complete). A write that returns the field to zero stores the word and sets bits 3:2 to 0.
- R8: `page_shift` equals the stored MPS plus 12, so the page is 2^(MPS+12) bytes.
- R9: Offset 0x24 holds the admin queue sizes. 0x28/0x2C hold the low and high words of the admin submission base, and 0x30/0x34 those of the admin completion base. A low-word write loads the low word and zeroes the high word. A high-word write ORs into the high word.
- R10: Writes to 0x1C, 0x38, 0x3C and any other unmapped offset change no register. A write of 0x4E564D65 at 0x20 pulses `sreset_unsup` for one cycle, and any other value written there produces no pulse.
- R11: Reads at or beyond offset 0x40, and reads of unlisted offsets below it, return zero.
- R12: An access with address bits 1:0 non-zero or `acc_bytes` below 4 sets the sticky flag `acc_err`. Such a write changes no register, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; `rdata` is valid the following cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| acc_bytes | input | 3 | Access size in bytes |
| queues_live | input | 1 | High while any admin or I/O queue exists |
| rdata | output | 32 | Registered read data |
| ctrl_clear | output | 1 | One-cycle pulse that clears the controller |
| page_shift | output | 5 | log2 of the configured page size |
| acc_err | output | 1 | Sticky flag for misaligned or narrow accesses |
| sreset_unsup | output | 1 | One-cycle pulse on an unsupported subsystem-reset request |

## Verification
The enable edge is exercised once with a fully valid setup and then with one start condition broken at a time. These cases cover a bad submission entry size, a bad completion entry size, a page code above the maximum, a page large enough to misalign an otherwise valid base, live queues, a zero admin size and a zero completion base. Each one shows whether that single term reaches the fatal flag. A second valid enable with a larger page separates the stored page code from the default shift. Writes with enable held, and the shutdown set and release sequence, separate edge detection from level detection. Misaligned, narrow, read-only and out-of-span accesses show that dropped writes leave all visible state unchanged.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int unsigned REG_SPAN   = 64;
  localparam int unsigned PAGE_BASE  = 12;
  localparam logic [31:0] SRST_KEY   = 32'h4E56_4D65;

  localparam logic [7:0] OFS_MSET  = 8'h0C;
  localparam logic [7:0] OFS_MCLR  = 8'h10;
  localparam logic [7:0] OFS_CFG   = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h1C;
  localparam logic [7:0] OFS_SRST  = 8'h20;
  localparam logic [7:0] OFS_AQA   = 8'h24;
  localparam logic [7:0] OFS_SQLO  = 8'h28;
  localparam logic [7:0] OFS_SQHI  = 8'h2C;
  localparam logic [7:0] OFS_CQLO  = 8'h30;
  localparam logic [7:0] OFS_CQHI  = 8'h34;

  localparam logic [3:0] STAT_READY = 4'h1;
  localparam logic [3:0] STAT_FATAL = 4'h2;
  localparam logic [1:0] SHST_DONE  = 2'b10;

  typedef struct packed {
    logic mset;
    logic mclr;
    logic cfg;
    logic srst;
    logic aqa;
    logic sqlo;
    logic sqhi;
    logic cqlo;
    logic cqhi;
  } wr_sel_t;

  function automatic logic cfg_en(input logic [31:0] c);
    return c[0];
  endfunction

  function automatic logic [3:0] cfg_mps(input logic [31:0] c);
    return c[10:7];
  endfunction

  function automatic logic cfg_shn_act(input logic [31:0] c);
    return |c[15:14];
  endfunction

  function automatic logic [3:0] cfg_sqes(input logic [31:0] c);
    return c[19:16];
  endfunction

  function automatic logic [3:0] cfg_cqes(input logic [31:0] c);
    return c[23:20];
  endfunction

  function automatic logic [4:0] page_shift_of(input logic [3:0] mps);
    return 5'(mps) + 5'(PAGE_BASE);
  endfunction

  function automatic logic [63:0] page_mask_of(input logic [3:0] mps);
    return (64'd1 << page_shift_of(mps)) - 64'd1;
  endfunction

  function automatic logic [11:0] aqa_sq_size(input logic [31:0] a);
    return a[11:0];
  endfunction

  function automatic logic [11:0] aqa_cq_size(input logic [31:0] a);
    return a[27:16];
  endfunction

endpackage

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        acc_bytes,
  output logic              bad_acc,
  output logic              rd_ok,
  output wr_sel_t           wr_sel
);

  logic aligned, full_word, legal, in_span, wr_go;
  logic [7:0] ofs;

  assign aligned   = (addr[1:0] == 2'b00);
  assign full_word = (acc_bytes >= 3'd4);
  assign legal     = aligned && full_word;
  assign in_span   = (addr < ADDR_W'(REG_SPAN));
  assign ofs       = addr[7:0];

  assign bad_acc = (wr_en || rd_en) && !legal;
  assign wr_go   = wr_en && legal && in_span;
  assign rd_ok   = rd_en && legal && in_span;

  always_comb begin
    wr_sel      = '0;
    wr_sel.mset = wr_go && (ofs == OFS_MSET);
    wr_sel.mclr = wr_go && (ofs == OFS_MCLR);
    wr_sel.cfg  = wr_go && (ofs == OFS_CFG);
    wr_sel.srst = wr_go && (ofs == OFS_SRST);
    wr_sel.aqa  = wr_go && (ofs == OFS_AQA);
    wr_sel.sqlo = wr_go && (ofs == OFS_SQLO);
    wr_sel.sqhi = wr_go && (ofs == OFS_SQHI);
    wr_sel.cqlo = wr_go && (ofs == OFS_CQLO);
    wr_sel.cqhi = wr_go && (ofs == OFS_CQHI);
  end

  // R12: an illegal access never selects a register
  always_comb begin
    if (bad_acc) a_no_sel_on_bad_r12: assert (wr_sel == '0 && !rd_ok);
  end

endmodule

// File: rtl/sctl_start_check.sv
module sctl_start_check
  import sctl_pkg::*;
#(
  parameter int MPS_MIN  = 0,
  parameter int MPS_MAX  = 4,
  parameter int SQES_MIN = 6,
  parameter int SQES_MAX = 6,
  parameter int CQES_MIN = 4,
  parameter int CQES_MAX = 4
) (
  input  logic [3:0]  mps,
  input  logic [3:0]  sqes,
  input  logic [3:0]  cqes,
  input  logic [11:0] sq_size,
  input  logic [11:0] cq_size,
  input  logic [63:0] sq_base,
  input  logic [63:0] cq_base,
  input  logic        queues_live,
  output logic        start_ok
);

  localparam int NCHK = 9;

  logic [63:0]     pmask;
  logic [NCHK-1:0] fail_vec;

  assign pmask = page_mask_of(mps);

  assign fail_vec[0] = queues_live;
  assign fail_vec[1] = (sq_base == 64'd0);
  assign fail_vec[2] = (cq_base == 64'd0);
  assign fail_vec[3] = |(sq_base & pmask);
  assign fail_vec[4] = |(cq_base & pmask);
  assign fail_vec[5] = (int'(mps) < MPS_MIN) || (int'(mps) > MPS_MAX);
  assign fail_vec[6] = (int'(sqes) < SQES_MIN) || (int'(sqes) > SQES_MAX);
  assign fail_vec[7] = (int'(cqes) < CQES_MIN) || (int'(cqes) > CQES_MAX);
  assign fail_vec[8] = (sq_size == 12'd0) || (cq_size == 12'd0);

  assign start_ok = (fail_vec == '0);

  // R5: a zero base can never pass
  always_comb begin
    if (sq_base == 64'd0 || cq_base == 64'd0) a_zero_base_fails_r5: assert (!start_ok);
  end

endmodule

// File: rtl/sctl_cc_fsm.sv
module sctl_cc_fsm
  import sctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cc_wr,
  input  logic [31:0] wdata,
  input  logic        start_ok,
  output logic [31:0] cc_q,
  output logic [3:0]  csts_q,
  output logic        ctrl_clear,
  output logic [4:0]  page_shift
);

  logic old_en, new_en, old_shn, new_shn;
  logic en_rise, en_fall, shn_rise, shn_fall, quiet, cc_store;
  logic [3:0] csts_nx;

  assign old_en  = cfg_en(cc_q);
  assign new_en  = cfg_en(wdata);
  assign old_shn = cfg_shn_act(cc_q);
  assign new_shn = cfg_shn_act(wdata);

  assign en_rise  = cc_wr &&  new_en && !old_en;
  assign en_fall  = cc_wr && !new_en &&  old_en;
  assign shn_rise = cc_wr &&  new_shn && !old_shn;
  assign shn_fall = cc_wr && !new_shn &&  old_shn;
  assign quiet    = cc_wr && !new_en && !old_en && !new_shn && !old_shn;
  assign cc_store = quiet || en_rise || en_fall || shn_rise || shn_fall;

  always_comb begin
    csts_nx = csts_q;
    if (en_rise)      csts_nx = start_ok ? STAT_READY : STAT_FATAL;
    else if (en_fall) csts_nx[0] = 1'b0;
    if (shn_rise)      csts_nx[3:2] = SHST_DONE;
    else if (shn_fall) csts_nx[3:2] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q       <= '0;
      csts_q     <= '0;
      ctrl_clear <= 1'b0;
    end else begin
      if (cc_store) cc_q <= wdata;
      csts_q     <= csts_nx;
      ctrl_clear <= en_fall || shn_rise;
    end
  end

  assign page_shift = page_shift_of(cfg_mps(cc_q));

  p_ready_on_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise && start_ok && !shn_rise |=> csts_q == STAT_READY);

  p_fatal_on_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise && !start_ok && !shn_rise |=> csts_q == STAT_FATAL);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !csts_q[0] && ctrl_clear);

  p_shdn_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shn_rise |=> csts_q[3:2] == SHST_DONE && ctrl_clear);

  p_cc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_wr |=> $stable(cc_q));

endmodule

// File: rtl/sctl_cfg_regs.sv
module sctl_cfg_regs
  import sctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int MPS_MIN  = 0,
  parameter int MPS_MAX  = 4,
  parameter int SQES_MIN = 6,
  parameter int SQES_MAX = 6,
  parameter int CQES_MIN = 4,
  parameter int CQES_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [2:0]        acc_bytes,
  input  logic              queues_live,
  output logic [31:0]       rdata,
  output logic              ctrl_clear,
  output logic [4:0]        page_shift,
  output logic              acc_err,
  output logic              sreset_unsup
);

  wr_sel_t     wr_sel;
  logic        bad_acc, rd_ok, start_ok;
  logic [31:0] imask, aqa, cc_q;
  logic [63:0] sq_base, cq_base;
  logic [3:0]  csts_q;
  logic [31:0] rd_mux;

  sctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .acc_bytes(acc_bytes),
    .bad_acc(bad_acc), .rd_ok(rd_ok), .wr_sel(wr_sel)
  );

  sctl_start_check #(
    .MPS_MIN(MPS_MIN), .MPS_MAX(MPS_MAX),
    .SQES_MIN(SQES_MIN), .SQES_MAX(SQES_MAX),
    .CQES_MIN(CQES_MIN), .CQES_MAX(CQES_MAX)
  ) u_chk (
    .mps(cfg_mps(wdata)), .sqes(cfg_sqes(wdata)), .cqes(cfg_cqes(wdata)),
    .sq_size(aqa_sq_size(aqa)), .cq_size(aqa_cq_size(aqa)),
    .sq_base(sq_base), .cq_base(cq_base),
    .queues_live(queues_live), .start_ok(start_ok)
  );

  sctl_cc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cc_wr(wr_sel.cfg), .wdata(wdata),
    .start_ok(start_ok), .cc_q(cc_q), .csts_q(csts_q),
    .ctrl_clear(ctrl_clear), .page_shift(page_shift)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask        <= '0;
      aqa          <= '0;
      sq_base      <= '0;
      cq_base      <= '0;
      acc_err      <= 1'b0;
      sreset_unsup <= 1'b0;
    end else begin
      if (wr_sel.mset) imask <= imask | wdata;
      if (wr_sel.mclr) imask <= imask & ~wdata;
      if (wr_sel.aqa)  aqa   <= wdata;
      if (wr_sel.sqlo) sq_base <= {32'h0, wdata};
      if (wr_sel.sqhi) sq_base <= sq_base | {wdata, 32'h0};
      if (wr_sel.cqlo) cq_base <= {32'h0, wdata};
      if (wr_sel.cqhi) cq_base <= cq_base | {wdata, 32'h0};
      if (bad_acc) acc_err <= 1'b1;
      sreset_unsup <= wr_sel.srst && (wdata == SRST_KEY);
    end
  end

  always_comb begin
    case (addr[7:0])
      OFS_MSET, OFS_MCLR: rd_mux = imask;
      OFS_CFG:            rd_mux = cc_q;
      OFS_STAT:           rd_mux = {28'h0, csts_q};
      OFS_AQA:            rd_mux = aqa;
      OFS_SQLO:           rd_mux = sq_base[31:0];
      OFS_SQHI:           rd_mux = sq_base[63:32];
      OFS_CQLO:           rd_mux = cq_base[31:0];
      OFS_CQHI:           rd_mux = cq_base[63:32];
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_ok ? rd_mux : '0;
  end

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel.mset |=> (imask & $past(wdata)) == $past(wdata));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);

  p_bad_wr_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc && wr_en |=> $stable(imask) && $stable(aqa) && $stable(sq_base) && $stable(cq_base));

  p_srst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_unsup |=> !sreset_unsup || $past(wr_en));

endmodule

// File: tb/sim_sctl_cfg_regs.sv
`timescale 1ns/1ps
module sim_sctl_cfg_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, queues_live = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  acc_bytes = 3'd4;
  logic [31:0] rdata;
  logic        ctrl_clear, acc_err, sreset_unsup;
  logic [4:0]  page_shift;

  int checks = 0, fails = 0;
  logic clr_seen, srst_seen;
  bit done = 0;

  always #2.5 clk = ~clk;

  sctl_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .acc_bytes(acc_bytes), .queues_live(queues_live),
    .rdata(rdata), .ctrl_clear(ctrl_clear), .page_shift(page_shift),
    .acc_err(acc_err), .sreset_unsup(sreset_unsup)
  );

  localparam logic [31:0] CC_IDLE = 32'h0046_0000;
  localparam logic [31:0] CC_GO   = 32'h0046_0001;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] nb = 3'd4);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; acc_bytes = nb;
    @(negedge clk);
    wr_en = 1'b0; acc_bytes = 3'd4;
    clr_seen = ctrl_clear;
    srst_seen = sreset_unsup;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d, input logic [2:0] nb = 3'd4);
    @(negedge clk);
    rd_en = 1'b1; addr = a; acc_bytes = nb;
    @(negedge clk);
    rd_en = 1'b0; acc_bytes = 3'd4;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    do_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 cc", 12'h014, 32'h0);
    rd_chk("R1 csts", 12'h01C, 32'h0);
    rd_chk("R1 mask", 12'h00C, 32'h0);
    chk("R1 page_shift", 32'(page_shift), 32'd12);
    chk("R1 acc_err", 32'(acc_err), 32'd0);
    chk("R1 ctrl_clear", 32'(ctrl_clear), 32'd0);
  endtask

  task automatic t_mask;
    do_wr(12'h00C, 32'h0000_00F0);
    do_wr(12'h00C, 32'h0000_0003);
    rd_chk("R2 set", 12'h00C, 32'h0000_00F3);
    rd_chk("R2 read at clr", 12'h010, 32'h0000_00F3);
    do_wr(12'h010, 32'h0000_0030);
    rd_chk("R2 clr", 12'h00C, 32'h0000_00C3);
  endtask

  task automatic t_admin;
    do_wr(12'h024, 32'h001F_001F);
    rd_chk("R9 aqa", 12'h024, 32'h001F_001F);
    do_wr(12'h028, 32'h0000_1000);
    do_wr(12'h02C, 32'h0000_0001);
    rd_chk("R9 sq hi", 12'h02C, 32'h1);
    rd_chk("R9 sq lo", 12'h028, 32'h1000);
    do_wr(12'h028, 32'h0000_2000);
    rd_chk("R9 lo write zeroes hi", 12'h02C, 32'h0);
    do_wr(12'h030, 32'h0000_4000);
    do_wr(12'h034, 32'h0);
    rd_chk("R9 cq lo", 12'h030, 32'h4000);
  endtask

  task automatic t_start;
    do_wr(12'h014, CC_IDLE);
    rd_chk("R3 quiet store", 12'h014, CC_IDLE);
    rd_chk("R3 quiet csts", 12'h01C, 32'h0);
    do_wr(12'h014, CC_GO);
    rd_chk("R4 ready", 12'h01C, 32'h1);
    do_wr(12'h014, 32'h0046_0381);
    rd_chk("R3 held enable keeps cc", 12'h014, CC_GO);
    chk("R8 shift unchanged", 32'(page_shift), 32'd12);
    do_wr(12'h014, CC_IDLE);
    chk("R6 clear pulse", 32'(clr_seen), 32'd1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(ctrl_clear), 32'd0);
    rd_chk("R6 rdy clear", 12'h01C, 32'h0);
    rd_chk("R6 cc stored", 12'h014, CC_IDLE);
    do_wr(12'h014, 32'h0046_0081);
    rd_chk("R4 ready mps1", 12'h01C, 32'h1);
    chk("R8 shift 13", 32'(page_shift), 32'd13);
    do_wr(12'h014, CC_IDLE);
  endtask

  task automatic try_en(input string req, input logic [31:0] c, input logic [31:0] exp);
    do_wr(12'h014, CC_IDLE);
    do_wr(12'h014, c);
    rd_chk(req, 12'h01C, exp);
  endtask

  task automatic t_fail;
    try_en("R5 sq entry size", 32'h0047_0001, 32'h2);
    try_en("R4 recovers", CC_GO, 32'h1);
    try_en("R5 cq entry size", 32'h0036_0001, 32'h2);
    try_en("R5 mps above max", 32'h0046_0281, 32'h2);
    try_en("R5 base misaligned", 32'h0046_0101, 32'h2);
    queues_live = 1'b1;
    try_en("R5 queues live", CC_GO, 32'h2);
    queues_live = 1'b0;
    do_wr(12'h024, 32'h001F_0000);
    try_en("R5 zero size", CC_GO, 32'h2);
    do_wr(12'h024, 32'h001F_001F);
    do_wr(12'h030, 32'h0);
    try_en("R5 zero cq base", CC_GO, 32'h2);
    do_wr(12'h030, 32'h0000_4000);
    try_en("R4 final ready", CC_GO, 32'h1);
  endtask

  task automatic t_shdn;
    do_wr(12'h014, 32'h0046_4001);
    chk("R7 clear on shutdown", 32'(clr_seen), 32'd1);
    rd_chk("R7 shst done", 12'h01C, 32'h9);
    rd_chk("R7 cc stored", 12'h014, 32'h0046_4001);
    do_wr(12'h014, CC_GO);
    chk("R7 no clear on release", 32'(clr_seen), 32'd0);
    rd_chk("R7 shst cleared", 12'h01C, 32'h1);
    rd_chk("R7 cc restored", 12'h014, CC_GO);
  endtask

  task automatic t_ignore;
    do_wr(12'h01C, 32'hFFFF_FFFF);
    do_wr(12'h038, 32'hFFFF_FFFF);
    do_wr(12'h03C, 32'hFFFF_FFFF);
    do_wr(12'h008, 32'hFFFF_FFFF);
    do_wr(12'h114, 32'h0);
    rd_chk("R10 csts unchanged", 12'h01C, 32'h1);
    rd_chk("R10 cc unchanged", 12'h014, CC_GO);
    rd_chk("R10 mask unchanged", 12'h00C, 32'h0000_00C3);
    do_wr(12'h020, 32'h1234_5678);
    chk("R10 other value no pulse", 32'(srst_seen), 32'd0);
    do_wr(12'h020, 32'h4E56_4D65);
    chk("R10 key pulse", 32'(srst_seen), 32'd1);
    rd_chk("R10 aqa unchanged", 12'h024, 32'h001F_001F);
    rd_chk("R11 beyond span", 12'h100, 32'h0);
    rd_chk("R11 unlisted 0x3C", 12'h03C, 32'h0);
    rd_chk("R11 unlisted 0x00", 12'h000, 32'h0);
  endtask

  task automatic t_badacc;
    logic [31:0] v;
    chk("R12 flag clear before", 32'(acc_err), 32'd0);
    do_wr(12'h016, 32'h0);
    chk("R12 flag on misaligned", 32'(acc_err), 32'd1);
    do_wr(12'h014, 32'h0, 3'd2);
    rd_chk("R12 narrow write dropped", 12'h014, CC_GO);
    rd_chk("R12 still ready", 12'h01C, 32'h1);
    do_rd(12'h014, v, 3'd2);
    chk("R12 narrow read zero", v, 32'h0);
    chk("R12 flag sticky", 32'(acc_err), 32'd1);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_admin;
    t_start;
    t_fail;
    t_shdn;
    t_ignore;
    t_badacc;
    finish_up;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up;
  end

endmodule